// File: doc/BRIEF.md
# Eight-Phase Startup Sequencer

This block moves a device from the moment its configuration image has finished loading to normal user operation. After a start request it counts through eight phases on its clock. Two of those phases can stall: one waits for a clock-manager lock indication and the other waits for an I/O impedance-calibration match. Each stall is switched on by its own enable pin. Once the gates are passed, the block releases the device I/O from the global high-impedance state. It then lets go of the open-drain done line. When the sensed done line reads high, it turns on global write enable and finally raises end-of-startup.

The done output is a release request and not a drive. An external pull-up and every other device on the same wired-AND line decide the level that `done_sense` reports. The sequencer holds in its done phase until that line reads high, so that all devices sharing it enable writes on the same edge. There is no data stream here and so no valid/ready handshake. All pins are plain level control and status signals. A low level on `rst_n` is the program/reset request. It returns the block to idle at once.

Top module: `boot_startup_seq`

## Requirements
- R1: While `rst_n` is low and immediately after it rises, all four outputs are low and the block is idle.
- R2: In the idle phase the block stays idle, with all outputs low, for as long as `start` is low. After leaving idle, `start` has no effect.
- R3: With `lock_wait_en` high the sequence stalls in the lock phase while `lock_ok` is low. With `lock_wait_en` low, `lock_ok` is ignored.
- R4: With `match_wait_en` high the sequence stalls in the match phase while `match_ok` is low. With `match_wait_en` low, `match_ok` is ignored.
- R5: When no stall applies, `start` sampled high at clock edge 1 gives the following results. `io_release` rises after edge 4, `done_release` after edge 5, `write_en` after edge 6 and `startup_end` after edge 7. Once an output is high it stays high until reset.
- R6: After `done_release` goes high, the block advances no further while `done_sense` is low. `write_en` rises on the first edge at which `done_sense` is sampled high.
- R7: `startup_end` rises one edge after `write_en` and then stays high, whatever the inputs, until reset.
- R8: Pulling `rst_n` low at any point clears all four outputs without waiting for a clock edge. The sequence then restarts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low program/reset |
| start | input | 1 | Start request, sampled in the idle phase |
| lock_wait_en | input | 1 | Enables the clock-manager lock stall |
| lock_ok | input | 1 | Clock-manager lock status |
| match_wait_en | input | 1 | Enables the impedance-match stall |
| match_ok | input | 1 | Impedance-calibration match status |
| done_sense | input | 1 | Sensed level of the shared wired-AND done line |
| io_release | output | 1 | High: global I/O tristate released |
| done_release | output | 1 | High: open-drain done output let go |
| write_en | output | 1 | Global write enable |
| startup_end | output | 1 | End-of-startup flag |

## Verification
All four outputs are decoded from a single phase register. Each one therefore changes exactly one clock edge after the edge that samples its enabling condition. This is one edge after `done_sense` for `write_en` and one edge after `write_en` for `startup_end`. The exception is reset, which clears the outputs without a clock edge. The bench drives inputs and samples outputs only on falling edges, so every result is read half a period after the rising edge that produced it. A reference phase model in the bench advances on the same rising edges. The directed sequence counts edges from the start request and expects `io_release` after edge 4 through `startup_end` after edge 7.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int NUM_PHASES = 8;
  localparam int PHASE_W    = $clog2(NUM_PHASES);
  localparam int NUM_CTRL   = 4;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE   = 3'd0,
    PH_LOCK   = 3'd1,
    PH_MATCH  = 3'd2,
    PH_SETTLE = 3'd3,
    PH_IO     = 3'd4,
    PH_DONE   = 3'd5,
    PH_WREN   = 3'd6,
    PH_END    = 3'd7
  } phase_e;

  // First phase in which control output idx is active (0 io, 1 done, 2 write, 3 end)
  function automatic phase_e ctrl_phase(input int idx);
    case (idx)
      0:       return PH_IO;
      1:       return PH_DONE;
      2:       return PH_WREN;
      default: return PH_END;
    endcase
  endfunction
endpackage

// File: rtl/sbs_gate.sv
module sbs_gate
  import sbs_pkg::*;
(
  input  phase_e phase,
  input  logic   start,
  input  logic   lock_wait_en,
  input  logic   lock_ok,
  input  logic   match_wait_en,
  input  logic   match_ok,
  input  logic   done_sense,
  output logic   advance
);
  always_comb begin
    unique case (phase)
      PH_IDLE:   advance = start;
      PH_LOCK:   advance = !lock_wait_en || lock_ok;
      PH_MATCH:  advance = !match_wait_en || match_ok;
      PH_SETTLE: advance = 1'b1;
      PH_IO:     advance = 1'b1;
      PH_DONE:   advance = done_sense;
      PH_WREN:   advance = 1'b1;
      PH_END:    advance = 1'b0;
      default:   advance = 1'b0;
    endcase
  end
endmodule

// File: rtl/sbs_phase_ctr.sv
module sbs_phase_ctr
  import sbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance,
  output phase_e phase
);
  logic [PHASE_W-1:0] nxt;
  assign nxt = phase + PHASE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= PH_IDLE;
    else if (advance) phase <= phase_e'(nxt);
  end
endmodule

// File: rtl/sbs_out_decode.sv
module sbs_out_decode
  import sbs_pkg::*;
(
  input  phase_e              phase,
  output logic [NUM_CTRL-1:0] ctrl
);
  for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_ctrl
    localparam phase_e FIRST = ctrl_phase(gi);
    assign ctrl[gi] = (phase >= FIRST);
  end
endmodule

// File: rtl/boot_startup_seq.sv
module boot_startup_seq
  import sbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lock_wait_en,
  input  logic lock_ok,
  input  logic match_wait_en,
  input  logic match_ok,
  input  logic done_sense,
  output logic io_release,
  output logic done_release,
  output logic write_en,
  output logic startup_end
);
  phase_e              phase;
  logic                advance;
  logic [NUM_CTRL-1:0] ctrl;

  sbs_gate u_gate (
    .phase(phase), .start(start),
    .lock_wait_en(lock_wait_en), .lock_ok(lock_ok),
    .match_wait_en(match_wait_en), .match_ok(match_ok),
    .done_sense(done_sense), .advance(advance)
  );

  sbs_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .advance(advance), .phase(phase)
  );

  sbs_out_decode u_dec (
    .phase(phase), .ctrl(ctrl)
  );

  assign io_release   = ctrl[0];
  assign done_release = ctrl[1];
  assign write_en     = ctrl[2];
  assign startup_end  = ctrl[3];
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   start,
  input logic   lock_wait_en,
  input logic   lock_ok,
  input logic   match_wait_en,
  input logic   match_ok,
  input logic   done_sense,
  input logic   io_release,
  input logic   done_release,
  input logic   write_en,
  input logic   startup_end,
  input phase_e phase
);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start) |=> (phase == PH_IDLE && !io_release));

  assert_lock_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOCK && lock_wait_en && !lock_ok) |=> (phase == PH_LOCK));

  assert_match_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MATCH && match_wait_en && !match_ok) |=> (phase == PH_MATCH));

  assert_order_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_release |-> io_release);

  assert_order_wren_R5: assert property (@(posedge clk) disable iff (!rst_n)
    write_en |-> done_release);

  assert_done_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_release && !write_en && !done_sense) |=> !write_en);

  assert_end_after_wren_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup_end) |-> $past(write_en));

  assert_end_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    startup_end |=> startup_end);
endmodule

bind boot_startup_seq sbs_checker u_chk (.*);

// File: tb/sim_boot_startup_seq.sv
`timescale 1ns/1ps
module sim_boot_startup_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, lock_wait_en = 1'b0, lock_ok = 1'b0;
  logic match_wait_en = 1'b0, match_ok = 1'b0, done_sense = 1'b0;
  logic io_release, done_release, write_en, startup_end;
  int checks = 0, fails = 0;
  int mph = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  boot_startup_seq u0 (.*);

  // Reference phase model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mph <= 0;
    else begin
      case (mph)
        0: if (start) mph <= 1;
        1: if (!lock_wait_en || lock_ok) mph <= 2;
        2: if (!match_wait_en || match_ok) mph <= 3;
        3, 4, 6: mph <= mph + 1;
        5: if (done_sense) mph <= 6;
        default: mph <= mph;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_model();
    chk("R5", "io_release(model)", io_release, mph >= 4);
    chk("R6", "done_release(model)", done_release, mph >= 5);
    chk("R6", "write_en(model)", write_en, mph >= 6);
    chk("R7", "startup_end(model)", startup_end, mph >= 7);
  endtask

  task automatic tick();
    @(negedge clk);
    chk_model();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240607));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "io_release in reset", io_release, 1'b0);
    chk("R1", "startup_end in reset", startup_end, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1", "write_en after reset", write_en, 1'b0);
    // R2: idle without start
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R2", "io_release while idle", io_release, 1'b0);
    end
    // R5: no-wait timing, edges counted from start sample
    done_sense = 1'b1;
    start = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      tick();
      start = 1'b0;
      chk("R5", "io_release timing", io_release, k >= 4);
      chk("R5", "done_release timing", done_release, k >= 5);
      chk("R5", "write_en timing", write_en, k >= 6);
      chk("R5", "startup_end timing", startup_end, k >= 7);
    end
    // R7 / R2: start after leaving idle has no effect
    start = 1'b1;
    done_sense = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R7", "startup_end sticky", startup_end, 1'b1);
      chk("R2", "write_en unaffected by start", write_en, 1'b1);
    end
    start = 1'b0;
    // R8: asynchronous clear
    #3 rst_n = 1'b0;
    #1;
    chk("R8", "io_release after reset", io_release, 1'b0);
    chk("R8", "startup_end after reset", startup_end, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: lock stall
    lock_wait_en = 1'b1; lock_ok = 1'b0; start = 1'b1;
    tick();
    start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R3", "io_release during lock stall", io_release, 1'b0);
    end
    // R4: match stall
    lock_ok = 1'b1; match_wait_en = 1'b1; match_ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R4", "io_release during match stall", io_release, 1'b0);
    end
    // R6: done stall
    match_ok = 1'b1; done_sense = 1'b0;
    for (int i = 0; i < 8; i++) tick();
    chk("R6", "io_release before done", io_release, 1'b1);
    chk("R6", "done_release before done", done_release, 1'b1);
    chk("R6", "write_en held by low done", write_en, 1'b0);
    done_sense = 1'b1;
    tick();
    chk("R6", "write_en after done high", write_en, 1'b1);
    chk("R7", "startup_end one edge later pending", startup_end, 1'b0);
    tick();
    chk("R7", "startup_end asserted", startup_end, 1'b1);
    // R3/R4: disabled waits ignore status
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lock_wait_en = 1'b0; lock_ok = 1'b0; match_wait_en = 1'b0; match_ok = 1'b0;
    start = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      start = 1'b0;
    end
    chk("R3", "lock ignored when disabled", io_release, 1'b1);
    chk("R4", "match ignored when disabled", io_release, 1'b1);
    // Random mix checked against the model
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 64) == 0) begin
        rst_n = 1'b0;
        lock_wait_en = $urandom % 2;
        match_wait_en = $urandom % 2;
      end else rst_n = 1'b1;
      start = ($urandom % 4) == 0;
      lock_ok = ($urandom % 3) == 0;
      match_ok = ($urandom % 3) == 0;
      done_sense = ($urandom % 3) == 0;
      tick();
    end
    summary();
  end
endmodule